// File: doc/BRIEF.md
# Synchronous Serial Channel Transmitter

This block turns bytes handed over by a host into a serial bit stream on one communications channel. Bytes enter through a valid/ready push port into a small queue. A shift register sends them least significant bit first, one bit for each pulse of a transmit clock enable that comes from the line side. In the two synchronous modes, a two-byte sync pattern goes out ahead of the first queued byte each time the transmitter leaves idle. In the asynchronous mode only the queued bytes are sent. Framing such as CRC, bit stuffing and start/stop bits belongs to other blocks.

A control write sets the enable bit and the two-bit mode field. A separate write loads the 16-bit sync pattern. Clearing the enable bit is an abort and does not drain pending data. On that same clock edge the queue is emptied, the shift register is cleared with any part-sent character, and the line goes to its idle-high level. No transmit clock enable pulse is needed for this.

Top module: `chan_tx`

## Requirements
- R1: After reset, txd is 1, push_ready is 0, the enable bit is 0, the mode is 00 and the sync pattern is 0x7E7E.
- R2: txd is 1 whenever no character is being shifted, and always while the transmitter is disabled.
- R3: In modes 00 and 11, leaving idle sends the low sync byte (pattern bits 7:0) and then the high sync byte (bits 15:8), before the first queued byte.
- R4: In mode 01 the queued bytes are sent with no sync bytes ahead of them.
- R5: Each character goes out LSB first. txd advances by exactly one bit per line_tick pulse and holds steady between pulses.
- R6: When another byte is waiting, it loads on the same clock as the last bit of the previous character completes, so the bit stream has no gap.
- R7: The queue holds 4 bytes. push_ready is 0 while it is full, and a push offered while push_ready is 0 is dropped.
- R8: Queued bytes are sent in the order they were pushed.
- R9: A control write that clears the enable bit aborts on its own clock edge with no line_tick. From the next cycle txd is 1, the queued bytes are discarded, and the part-sent character never resumes.
- R10: Mode 10 acts as disabled even with the enable bit set: txd stays 1 and pushes are refused.
- R11: push_ready is 0 while the transmitter is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr | input | 1 | Write strobe for the enable bit and the mode field |
| ctl_en | input | 1 | Enable value written by ctl_wr |
| ctl_mode | input | 2 | Mode written by ctl_wr: 00 HDLC, 01 async, 10 reserved, 11 BISYNC/transparent |
| syn_wr | input | 1 | Write strobe for the sync pattern |
| syn_pat | input | 16 | Sync pattern value; bits 7:0 go out first, bits 15:8 second |
| push_valid | input | 1 | Host offers a byte |
| push_data | input | 8 | Byte offered |
| push_ready | output | 1 | Byte is taken on an edge where push_valid and push_ready are both 1 |
| line_tick | input | 1 | Transmit clock enable, one pulse per line bit |
| txd | output | 1 | Serial data out, idle high |

## Verification
A byte is accepted on the edge where push_valid meets push_ready. Transmission starts on the next edge, so the first bit is on txd two edges after the push was driven. From then on, each edge that sees line_tick moves txd to the next bit, and a control write that disables the block forces txd high right after its own edge. The bench drives all inputs and samples txd and push_ready at the falling edge, where every register has settled. It waits two cycles after a push before it issues the first tick. Each tick lasts exactly one rising edge, and the bench reads the bit before that tick.

// File: rtl/chan_tx_pkg.sv
// Package: shared encodings for the channel transmitter.
// Assumes: mode codes are fixed by the control field layout.
package chan_tx_pkg;

    typedef enum logic [1:0] {
        MODE_HDLC  = 2'b00,
        MODE_ASYNC = 2'b01,
        MODE_RSV   = 2'b10,
        MODE_SYNC  = 2'b11
    } tx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PRE1 = 2'b01,
        ST_PRE2 = 2'b10,
        ST_DATA = 2'b11
    } tx_state_e;

    // True for the modes that send the sync pattern before data.
    function automatic logic mode_uses_sync(input tx_mode_e m);
        return (m == MODE_HDLC) || (m == MODE_SYNC);
    endfunction

    // True for modes in which the transmitter can run.
    function automatic logic mode_runs(input tx_mode_e m);
        return m != MODE_RSV;
    endfunction

endpackage

// File: rtl/chan_tx_cfg.sv
// Module: control and sync pattern registers.
// Holds the enable bit, mode field and sync pattern. Produces the
// run qualifier and a flush that fires on the very edge of a
// disabling write, so the abort needs no line clock.
// Assumes: ctl_wr and syn_wr are single-cycle strobes from the host.
module chan_tx_cfg
    import chan_tx_pkg::*;
#(
    parameter int          SYNC_W     = 16,
    parameter logic [15:0] RESET_SYNC = 16'h7E7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_en,
    input  logic [1:0]        ctl_mode,
    input  logic              syn_wr,
    input  logic [SYNC_W-1:0] syn_pat,
    output logic              active,
    output tx_mode_e          mode,
    output logic [SYNC_W-1:0] sync_q,
    output logic              flush
);

    logic     en_q;
    tx_mode_e mode_q;
    logic     wr_runs;

    // Purpose: decide whether the value being written lets the channel run.
    always_comb begin
        wr_runs = ctl_en && mode_runs(tx_mode_e'(ctl_mode));
    end

    // Purpose: control register, reset to disabled HDLC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= MODE_HDLC;
        end else if (ctl_wr) begin
            en_q   <= ctl_en;
            mode_q <= tx_mode_e'(ctl_mode);
        end
    end

    // Purpose: sync pattern register, reset to two flag bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= SYNC_W'(RESET_SYNC);
        end else if (syn_wr) begin
            sync_q <= syn_pat;
        end
    end

    // Purpose: export run state and the abort/flush request.
    always_comb begin
        active = en_q && mode_runs(mode_q);
        mode   = mode_q;
        flush  = (ctl_wr && !wr_runs) || !active;
    end

endmodule

// File: rtl/chan_tx_fifo.sv
// Module: transmit data queue.
// Circular buffer with a full/empty count. A flush empties it at once.
// Assumes: the writer never writes when full and the reader never
// reads when empty (the callers gate both).
module chan_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    // Purpose: advance a pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Purpose: store a pushed byte.
    always_ff @(posedge clk) begin
        if (wr) begin
            mem[wp] <= wdata;
        end
    end

    // Purpose: pointers and occupancy count, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr) wp <= bump(wp);
            if (rd) rp <= bump(rp);
            case ({wr, rd})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Purpose: status flags and head-of-queue data.
    always_comb begin
        full  = (cnt == CW'(DEPTH));
        empty = (cnt == '0);
        rdata = mem[rp];
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr);

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/chan_tx_shift.sv
// Module: parallel-to-serial shifter.
// Loads a character, presents bit 0 on txd, and moves to the next bit
// on each tick. It flags the tick that ends the last bit so that a
// new load can share that cycle. Idle output is 1.
// Assumes: load is only raised when idle or together with last.
module chan_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         txd,
    output logic         last
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;
    logic          busy;

    // Purpose: flag the tick that completes the final bit.
    always_comb begin
        last = busy && tick && (cnt == CW'(W - 1));
        txd  = busy ? sh[0] : 1'b1;
    end

    // Purpose: shift state; flush discards any part-sent character.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            sh   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (load) begin
            sh   <= din;
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy && tick) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                sh  <= sh >> 1;
                cnt <= cnt + CW'(1);
            end
        end
    end

    assert_load_gapless_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!busy || last));

    assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !load && !flush) |=> $stable(txd));

    assert_end_goes_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load && !flush) |=> txd);

endmodule

// File: rtl/chan_tx_seq.sv
// Module: transmit sequencer.
// Picks what the shifter sends next. In synchronous modes, low sync
// byte then high sync byte then queued data; in async mode, queued
// data only. Returns to idle when the queue runs dry.
// Assumes: the shifter reports last on the tick that ends a character.
module chan_tx_seq
    import chan_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active,
    input  tx_mode_e       mode,
    input  logic [2*W-1:0] sync_pat,
    input  logic           empty,
    input  logic [W-1:0]   head,
    input  logic           last,
    output logic           load,
    output logic [W-1:0]   load_byte,
    output logic           pop
);

    tx_state_e st, st_nxt;

    // Purpose: next-state and load/pop decisions.
    always_comb begin
        st_nxt    = st;
        load      = 1'b0;
        pop       = 1'b0;
        load_byte = head;
        if (!active) begin
            st_nxt = ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (!empty) begin
                        load = 1'b1;
                        if (mode_uses_sync(mode)) begin
                            load_byte = sync_pat[W-1:0];
                            st_nxt    = ST_PRE1;
                        end else begin
                            pop    = 1'b1;
                            st_nxt = ST_DATA;
                        end
                    end
                end
                ST_PRE1: begin
                    if (last) begin
                        load      = 1'b1;
                        load_byte = sync_pat[2*W-1:W];
                        st_nxt    = ST_PRE2;
                    end
                end
                default: begin
                    if (last) begin
                        if (!empty) begin
                            load   = 1'b1;
                            pop    = 1'b1;
                            st_nxt = ST_DATA;
                        end else begin
                            st_nxt = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // Purpose: sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    assert_sync_before_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && mode_uses_sync(mode)) |-> (st == ST_PRE2 || st == ST_DATA));

    assert_async_no_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && load && mode == MODE_ASYNC) |-> pop);

    assert_pre1_to_pre2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRE1 && last && active) |=> (st == ST_PRE2));

endmodule

// File: rtl/chan_tx.sv
// Module: synchronous serial channel transmitter (top).
// Host pushes bytes through valid/ready; they are queued and shifted
// out LSB first on line_tick, preceded by the sync pattern in the
// synchronous modes. A disabling control write aborts at once.
// Assumes: line_tick is synchronous to clk and one cycle wide per bit.
module chan_tx
    import chan_tx_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter int          FIFO_DEPTH = 4,
    parameter logic [15:0] RESET_SYNC = 16'h7E7E
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic                ctl_en,
    input  logic [1:0]          ctl_mode,
    input  logic                syn_wr,
    input  logic [2*DATA_W-1:0] syn_pat,
    input  logic                push_valid,
    input  logic [DATA_W-1:0]   push_data,
    output logic                push_ready,
    input  logic                line_tick,
    output logic                txd
);

    localparam int SYNC_W = 2 * DATA_W;

    logic              active;
    tx_mode_e          mode;
    logic [SYNC_W-1:0] sync_q;
    logic              flush;
    logic              q_full, q_empty, q_pop, q_push;
    logic [DATA_W-1:0] q_head;
    logic              sh_load, sh_last;
    logic [DATA_W-1:0] sh_byte;

    chan_tx_cfg #(.SYNC_W(SYNC_W), .RESET_SYNC(RESET_SYNC)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_en   (ctl_en),
        .ctl_mode (ctl_mode),
        .syn_wr   (syn_wr),
        .syn_pat  (syn_pat),
        .active   (active),
        .mode     (mode),
        .sync_q   (sync_q),
        .flush    (flush)
    );

    // Purpose: host handshake; refused while full or not running.
    always_comb begin
        push_ready = active && !q_full;
        q_push     = push_valid && push_ready && !flush;
    end

    chan_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .wr    (q_push),
        .wdata (push_data),
        .rd    (q_pop),
        .rdata (q_head),
        .full  (q_full),
        .empty (q_empty)
    );

    chan_tx_seq #(.W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active && !flush),
        .mode      (mode),
        .sync_pat  (sync_q),
        .empty     (q_empty),
        .head      (q_head),
        .last      (sh_last),
        .load      (sh_load),
        .load_byte (sh_byte),
        .pop       (q_pop)
    );

    chan_tx_shift #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .tick  (line_tick),
        .load  (sh_load),
        .din   (sh_byte),
        .txd   (txd),
        .last  (sh_last)
    );

    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> txd);

    assert_abort_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_en) |=> (txd && !push_ready));

    assert_reserved_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RSV) |-> (txd && !push_ready));

endmodule

// File: tb/test_chan_tx.sv
module test_chan_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_en = 1'b0;
    logic [1:0]  ctl_mode = 2'b00;
    logic        syn_wr = 1'b0;
    logic [15:0] syn_pat = '0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_data = '0;
    logic        push_ready;
    logic        line_tick = 1'b0;
    logic        txd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chan_tx i_chan_tx (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
        .ctl_mode(ctl_mode), .syn_wr(syn_wr), .syn_pat(syn_pat),
        .push_valid(push_valid), .push_data(push_data),
        .push_ready(push_ready), .line_tick(line_tick), .txd(txd)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ctl(input logic en, input logic [1:0] m);
        @(negedge clk); ctl_wr = 1'b1; ctl_en = en; ctl_mode = m;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic set_sync(input logic [15:0] p);
        @(negedge clk); syn_wr = 1'b1; syn_pat = p;
        @(negedge clk); syn_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); push_valid = 1'b1; push_data = d;
        @(negedge clk); push_valid = 1'b0;
    endtask

    // Read n bits, one tick each; bit i lands in v[i].
    task automatic rx_bits(input int n, output logic [63:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            v[i] = txd;
            line_tick = 1'b1;
            @(negedge clk);
            line_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        check(txd === 1'b1, "R1 txd after reset", txd, 1);
        check(push_ready === 1'b0, "R1 ready after reset", push_ready, 0);
    endtask

    task automatic t_hdlc_default;
        logic [63:0] v;
        set_ctl(1'b1, 2'b00);
        check(push_ready === 1'b1, "R11 ready once enabled", push_ready, 1);
        push(8'hA5);
        @(negedge clk);
        rx_bits(24, v);
        check(v[23:0] === 24'hA57E7E, "R1 R3 R5 default sync then byte", v[23:0], 24'hA57E7E);
        rx_bits(8, v);
        check(v[7:0] === 8'hFF, "R2 idle high after frame", v[7:0], 8'hFF);
    endtask

    task automatic t_async_order;
        logic [63:0] v;
        set_ctl(1'b1, 2'b01);
        push(8'h02);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            check(txd === 1'b0, "R5 holds bit without tick", txd, 0);
            @(negedge clk);
        end
        push(8'hC3);
        push(8'h96);
        rx_bits(24, v);
        check(v[23:0] === 24'h96C302, "R4 R6 R8 async gapless order", v[23:0], 24'h96C302);
        rx_bits(4, v);
        check(v[3:0] === 4'hF, "R2 idle after async", v[3:0], 4'hF);
    endtask

    task automatic t_bisync_pattern;
        logic [63:0] v;
        set_ctl(1'b1, 2'b11);
        set_sync(16'h1632);
        push(8'h4B);
        @(negedge clk);
        rx_bits(24, v);
        check(v[23:0] === 24'h4B1632, "R3 low sync byte first in mode 11", v[23:0], 24'h4B1632);
    endtask

    task automatic t_full;
        logic [63:0] v;
        set_ctl(1'b1, 2'b00);
        set_sync(16'h7E7E);
        push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        check(push_ready === 1'b0, "R7 ready low when full", push_ready, 0);
        push(8'h55);
        rx_bits(48, v);
        check(v[47:0] === 48'h443322117E7E, "R7 R8 four bytes kept", v[47:0], 48'h443322117E7E);
        rx_bits(8, v);
        check(v[7:0] === 8'hFF, "R7 dropped push not sent", v[7:0], 8'hFF);
    endtask

    task automatic t_abort;
        logic [63:0] v;
        set_ctl(1'b1, 2'b00);
        push(8'h5A);
        push(8'h81);
        rx_bits(5, v);
        check(v[4:0] === 5'h1E, "R9 partial sync before abort", v[4:0], 5'h1E);
        set_ctl(1'b0, 2'b00);
        check(txd === 1'b1, "R9 txd high without tick", txd, 1);
        check(push_ready === 1'b0, "R11 ready low when disabled", push_ready, 0);
        rx_bits(8, v);
        check(v[7:0] === 8'hFF, "R2 idle while disabled", v[7:0], 8'hFF);
        set_ctl(1'b1, 2'b00);
        rx_bits(16, v);
        check(v[15:0] === 16'hFFFF, "R9 queue and shifter flushed", v[15:0], 16'hFFFF);
        push(8'h3C);
        @(negedge clk);
        rx_bits(24, v);
        check(v[23:0] === 24'h3C7E7E, "R9 fresh start after abort", v[23:0], 24'h3C7E7E);
    endtask

    task automatic t_reserved;
        logic [63:0] v;
        set_ctl(1'b1, 2'b10);
        check(push_ready === 1'b0, "R10 ready low in mode 10", push_ready, 0);
        push(8'h00);
        rx_bits(8, v);
        check(v[7:0] === 8'hFF, "R10 txd high in mode 10", v[7:0], 8'hFF);
        set_ctl(1'b1, 2'b01);
        @(negedge clk);
        rx_bits(8, v);
        check(v[7:0] === 8'hFF, "R10 refused push never sent", v[7:0], 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hdlc_default();
        t_async_order();
        t_bisync_pattern();
        t_full();
        t_abort();
        t_reserved();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule